// File: doc/BRIEF.md
# Interrupt Acknowledge Opcode Responder

This block sits between a small group of interrupt sources and an 8-bit processor whose interrupt scheme is a single request line plus an enable output. Each source is captured on its low-to-high transition into a pending set. While at least one source is pending, the block raises its request toward the processor, but only while the processor reports that it can take interrupts.

The processor marks every machine cycle by putting a status byte on the data bus in the cycle's first clock state. When the acknowledge bit of that byte is set, the block chooses the highest-priority pending source. In the opcode-fetch read slot of the same machine cycle it answers with a complete one-byte restart instruction whose target address is eight times the source index. If nothing is pending, it answers with all ones. An idle, pulled-up bus would read the same value, which is the lowest-priority restart.

After it has answered, the block ignores further acknowledges until the processor's enable output has gone low and then high again. This keeps one acceptance from producing two answers. Its bus drivers are enabled only in the read slot of an armed acknowledge.

Top module: `ack_opcode_responder`

## Requirements
- R1: A source becomes pending only on a low-to-high change of its input seen on a clock edge. A source held high does not become pending again, and a source already high when reset is released is not latched.
- R2: `intReq` is high exactly when `intEnable` is high and at least one source is pending. A pending source stays pending while `intEnable` is low.
- R3: A machine cycle is armed as an acknowledge only when `statusValid` is high and bit 0 of `dataIn` is 1. A status byte with bit 0 at 0 does not arm, and the following read slot drives nothing.
- R4: `dataOutEn` is high only while `readStrobe` is high in an armed acknowledge cycle. Whenever `dataOutEn` is low, `dataOut` is 8'h00.
- R5: The driven byte is binary 11nnn111, where nnn is the lowest-numbered pending source (index 0 wins). The choice is fixed when the status byte is sampled, so a source that becomes pending later in the same machine cycle does not change it.
- R6: An acknowledge with no source pending drives 8'hFF.
- R7: On the clock edge that ends the drive, the chosen source's pending bit clears and every other pending bit is kept.
- R8: After a drive, acknowledge status bytes are ignored and nothing is driven until `intEnable` has been seen low and then high on later clock edges.
- R9: After reset, no source is pending, `intReq` is 0, `dataOutEn` is 0 and `dataOut` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcReq | input | NUM_SRC (8) | Request inputs from the sources, captured on rising level change |
| intEnable | input | 1 | Processor's interrupt-enable output |
| statusValid | input | 1 | High in the first clock state of a machine cycle, when the status byte is on the bus |
| readStrobe | input | 1 | High in the processor's data-read slot |
| dataIn | input | 8 | Data bus as seen by the block (status byte) |
| intReq | output | 1 | Interrupt request toward the processor |
| dataOut | output | 8 | Restart opcode driven onto the bus |
| dataOutEn | output | 1 | Bus driver enable |

## Verification
On every cycle, the bound checker enforces several rules. The bus driver is on only in a read slot and never for two cycles running. The driven byte always has the restart bit pattern, and the bus value is zero while the driver is off. The request never appears without enable. No answer is given between a drive and the next low-then-high of enable. Only directed scenarios can show which source wins, that the opcode is frozen at status time, that the winner alone is cleared, and the all-ones default with nothing pending. The same holds for a non-acknowledge status byte, a held-high or reset-time input, and a request kept pending while enable is low.

// File: rtl/ack_resp_pkg.sv
package ack_resp_pkg;

  // Strobes from control to datapath.
  typedef struct packed {
    logic captureSel;  // freeze the priority choice at status time
    logic clearSel;    // retire the chosen source's pending bit
    logic driveBus;    // enable the bus drivers this cycle
  } ctrlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_LOCKED = 2'd2,
    ST_REARM  = 2'd3
  } ackState_t;

  localparam int unsigned IDX_W = 3;
  localparam logic [7:0] OPC_DEFAULT = 8'hFF;

  // Restart to address idx*8: 11 idx 111
  function automatic logic [7:0] restartOpcode(input logic [IDX_W-1:0] idx);
    return {2'b11, idx, 3'b111};
  endfunction

endpackage

// File: rtl/src_edge_latch.sv
module src_edge_latch (
  input  logic clk,
  input  logic rstN,
  input  logic srcLvl,
  output logic srcRise
);
  logic prevLvl;

  // Reset to one so an input already high at reset release is not a rise.
  always_ff @(posedge clk) begin
    if (!rstN) prevLvl <= 1'b1;
    else       prevLvl <= srcLvl;
  end

  assign srcRise = srcLvl & ~prevLvl;
endmodule

// File: rtl/ack_resp_ctrl.sv
module ack_resp_ctrl
  import ack_resp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        statusValid,
  input  logic        ackBit,
  input  logic        readStrobe,
  input  logic        intEnable,
  output ctrlStrobe_t strobe
);
  ackState_t state, stateNext;

  always_comb begin
    stateNext         = state;
    strobe            = '0;
    unique case (state)
      ST_IDLE: begin
        if (statusValid && ackBit) begin
          strobe.captureSel = 1'b1;
          stateNext         = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (statusValid) begin
          // A new machine cycle began before the read slot: re-evaluate.
          strobe.captureSel = ackBit;
          stateNext         = ackBit ? ST_ARMED : ST_IDLE;
        end else if (readStrobe) begin
          strobe.driveBus = 1'b1;
          strobe.clearSel = 1'b1;
          stateNext       = ST_LOCKED;
        end
      end
      ST_LOCKED: begin
        if (!intEnable) stateNext = ST_REARM;
      end
      ST_REARM: begin
        if (intEnable) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/ack_resp_datapath.sv
module ack_resp_datapath
  import ack_resp_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               intEnable,
  input  ctrlStrobe_t        strobe,
  output logic               intReq,
  output logic [7:0]         dataOut,
  output logic               dataOutEn
);
  logic [NUM_SRC-1:0] srcRise;
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] pendingNext;
  logic [IDX_W-1:0]   encIdx;
  logic               encAny;
  logic [IDX_W-1:0]   selIdx;
  logic               selValid;
  logic [7:0]         opcodeReg;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    src_edge_latch u_edge (
      .clk    (clk),
      .rstN   (rstN),
      .srcLvl (srcReq[g]),
      .srcRise(srcRise[g])
    );

    // New rise wins over a clear in the same cycle.
    assign pendingNext[g] = srcRise[g] |
      (pending[g] & ~(strobe.clearSel & selValid & (selIdx == IDX_W'(g))));
  end

  always_ff @(posedge clk) begin
    if (!rstN) pending <= '0;
    else       pending <= pendingNext;
  end

  // Lowest index has highest priority.
  always_comb begin
    encIdx = '0;
    encAny = |pending;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pending[i]) encIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selIdx    <= '0;
      selValid  <= 1'b0;
      opcodeReg <= OPC_DEFAULT;
    end else if (strobe.captureSel) begin
      selIdx    <= encIdx;
      selValid  <= encAny;
      opcodeReg <= encAny ? restartOpcode(encIdx) : OPC_DEFAULT;
    end
  end

  assign intReq    = intEnable & encAny;
  assign dataOutEn = strobe.driveBus;
  assign dataOut   = strobe.driveBus ? opcodeReg : 8'h00;
endmodule

// File: rtl/ack_opcode_responder.sv
module ack_opcode_responder
  import ack_resp_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned ACK_BIT = 0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               intEnable,
  input  logic               statusValid,
  input  logic               readStrobe,
  input  logic [7:0]         dataIn,
  output logic               intReq,
  output logic [7:0]         dataOut,
  output logic               dataOutEn
);
  ctrlStrobe_t strobe;
  logic        unusedStatus;

  assign unusedStatus = ^(dataIn & ~(8'd1 << ACK_BIT));

  ack_resp_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .statusValid(statusValid),
    .ackBit     (dataIn[ACK_BIT]),
    .readStrobe (readStrobe),
    .intEnable  (intEnable),
    .strobe     (strobe)
  );

  ack_resp_datapath #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .srcReq   (srcReq),
    .intEnable(intEnable),
    .strobe   (strobe),
    .intReq   (intReq),
    .dataOut  (dataOut),
    .dataOutEn(dataOutEn)
  );
endmodule

// File: rtl/ack_opcode_responder_chk.sv
module ack_opcode_responder_chk (
  input logic       clk,
  input logic       rstN,
  input logic       intEnable,
  input logic       readStrobe,
  input logic       intReq,
  input logic [7:0] dataOut,
  input logic       dataOutEn
);
  logic blocked;
  logic lowSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blocked <= 1'b0;
      lowSeen <= 1'b0;
    end else if (dataOutEn) begin
      blocked <= 1'b1;
      lowSeen <= 1'b0;
    end else if (blocked && !intEnable) begin
      lowSeen <= 1'b1;
    end else if (blocked && lowSeen && intEnable) begin
      blocked <= 1'b0;
      lowSeen <= 1'b0;
    end
  end

  a_r2_req_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> intEnable);

  a_r4_drive_in_read_slot: assert property (@(posedge clk) disable iff (!rstN)
    dataOutEn |-> readStrobe);

  a_r4_quiet_bus_zero: assert property (@(posedge clk) disable iff (!rstN)
    !dataOutEn |-> (dataOut == 8'h00));

  a_r5_restart_pattern: assert property (@(posedge clk) disable iff (!rstN)
    dataOutEn |-> (dataOut[7:6] == 2'b11 && dataOut[2:0] == 3'b111));

  a_r8_single_drive: assert property (@(posedge clk) disable iff (!rstN)
    dataOutEn |=> !dataOutEn);

  a_r8_locked_until_reenable: assert property (@(posedge clk) disable iff (!rstN)
    blocked |-> !dataOutEn);
endmodule

bind ack_opcode_responder ack_opcode_responder_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .intEnable (intEnable),
  .readStrobe(readStrobe),
  .intReq    (intReq),
  .dataOut   (dataOut),
  .dataOutEn (dataOutEn)
);

// File: tb/ack_opcode_responder_bench.sv
module ack_opcode_responder_bench;
  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] srcReq;
  logic       intEnable;
  logic       statusValid;
  logic       readStrobe;
  logic [7:0] dataIn;
  logic       intReq;
  logic [7:0] dataOut;
  logic       dataOutEn;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  ack_opcode_responder u_ack_opcode_responder (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .intEnable(intEnable),
    .statusValid(statusValid), .readStrobe(readStrobe), .dataIn(dataIn),
    .intReq(intReq), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic pulseSrc(input logic [7:0] mask);
    srcReq = srcReq | mask; step();
    srcReq = srcReq & ~mask; step();
  endtask

  task automatic reenable();
    intEnable = 1'b0; step();
    intEnable = 1'b1; step();
  endtask

  task automatic ackCycle(input string req, input logic expDrive, input logic [7:0] expOp);
    statusValid = 1'b1; dataIn = 8'hA3; step();
    statusValid = 1'b0; dataIn = 8'h00; step();
    readStrobe = 1'b1; #1;
    check(req, {7'd0, dataOutEn}, {7'd0, expDrive});
    check(req, dataOut, expDrive ? expOp : 8'h00);
    step(); readStrobe = 1'b0; #1;
    check("R4 drive ends with slot", {7'd0, dataOutEn}, 8'h00);
  endtask

  task automatic testReset();
    rstN = 1'b0; srcReq = 8'h20; intEnable = 1'b1;
    statusValid = 1'b0; readStrobe = 1'b0; dataIn = 8'h00;
    step(); step();
    rstN = 1'b1; step(); step();
    check("R9 intReq after reset", {7'd0, intReq}, 8'h00);
    check("R9 dataOutEn after reset", {7'd0, dataOutEn}, 8'h00);
    check("R9 dataOut after reset", dataOut, 8'h00);
    srcReq = 8'h00; step();
    check("R1 high-at-reset not latched", {7'd0, intReq}, 8'h00);
  endtask

  task automatic testEnableGate();
    intEnable = 1'b0;
    pulseSrc(8'h08);
    check("R2 no request while disabled", {7'd0, intReq}, 8'h00);
    intEnable = 1'b1; #1;
    check("R2 pending kept, request on enable", {7'd0, intReq}, 8'h01);
    step();
    ackCycle("R5 source 3 opcode", 1'b1, 8'hDF);
    check("R7 served source cleared", {7'd0, intReq}, 8'h00);
    reenable();
  endtask

  task automatic testPriority();
    pulseSrc(8'h44);
    ackCycle("R5 source 2 beats 6", 1'b1, 8'hD7);
    reenable();
    check("R7 other source kept", {7'd0, intReq}, 8'h01);
    ackCycle("R5 source 6 opcode", 1'b1, 8'hF7);
    reenable();
    check("R7 all served", {7'd0, intReq}, 8'h00);
  endtask

  task automatic testNoPending();
    ackCycle("R6 default all ones", 1'b1, 8'hFF);
    reenable();
  endtask

  task automatic testNonAck();
    pulseSrc(8'h02);
    statusValid = 1'b1; dataIn = 8'hA2; step();
    statusValid = 1'b0; dataIn = 8'h00; step();
    readStrobe = 1'b1; #1;
    check("R3 non-ack status no drive", {7'd0, dataOutEn}, 8'h00);
    check("R4 bus zero when off", dataOut, 8'h00);
    step(); readStrobe = 1'b0; step();
    readStrobe = 1'b1; #1;
    check("R4 bare read slot no drive", {7'd0, dataOutEn}, 8'h00);
    step(); readStrobe = 1'b0; step();
    check("R3 source still pending", {7'd0, intReq}, 8'h01);
    ackCycle("R5 source 1 opcode", 1'b1, 8'hCF);
    reenable();
  endtask

  task automatic testLock();
    pulseSrc(8'h81);
    ackCycle("R5 source 0 opcode", 1'b1, 8'hC7);
    ackCycle("R8 ack ignored while locked", 1'b0, 8'h00);
    check("R8 source 7 still requested", {7'd0, intReq}, 8'h01);
    reenable();
    ackCycle("R8 answer after reenable", 1'b1, 8'hFF);
    reenable();
    check("R8 source 7 served", {7'd0, intReq}, 8'h00);
  endtask

  task automatic testCaptureTime();
    pulseSrc(8'h20);
    statusValid = 1'b1; dataIn = 8'h01; step();
    statusValid = 1'b0; dataIn = 8'h00;
    srcReq = 8'h02; step();
    readStrobe = 1'b1; #1;
    check("R5 choice frozen at status", dataOut, 8'hEF);
    step(); readStrobe = 1'b0;
    reenable();
    check("R5 late source pending", {7'd0, intReq}, 8'h01);
    ackCycle("R5 late source served", 1'b1, 8'hCF);
    reenable();
    check("R1 held level not relatched", {7'd0, intReq}, 8'h00);
    srcReq = 8'h00; step();
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testEnableGate();
    testPriority();
    testNoPending();
    testNonAck();
    testLock();
    testCaptureTime();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule